// File: doc/BRIEF.md
# 5B/4B Receive Decoder with Stream Delimiters

This block sits between a descrambler and a MAC-side receive interface. It takes a serial bit stream, one bit per cycle in which the valid strobe is high, and looks for the start of a frame. Carrier sense is raised as soon as the idle stream shows a break. The block then checks for the two-group start delimiter. When it finds the delimiter, that point fixes the boundary of every 5-bit code group until the frame ends.

Inside a frame, each code group is turned into a 4-bit nibble on an MII-style receive interface. The interface has a data nibble, data valid, receive error and carrier sense. A one-cycle strobe marks each update of these outputs; it plays the part of the 25 MHz nibble enable. A frame ends on the end delimiter pair or on two idle groups in a row, and neither produces data. Code groups that are illegal inside a frame are flagged as errors. If the stream breaks but no start delimiter follows, the block reports a fixed error value with data valid low. It stays in this error condition until two idle groups arrive.

Top module: `pcs_rx_5b4b`

## Requirements
- R1: A bit is taken only in a cycle with `rx_bit_vld_i` high, and the value of `rx_bit_i` in other cycles has no effect. The first bit received of a code group is its leftmost bit as written below.
- R2: While searching, `mii_crs_o` rises one cycle after a received 0 bit for which three things hold: the bit before it was 1, a further 0 lies among the eight bits before that one, and only bits received since the search began are counted. Before this point `mii_crs_o` stays low, and a stream of 1 bits raises no strobe.
- R3: Three bits after carrier is raised, the block compares the last ten bits with J=11000 followed by K=10001. On a match it aligns groups from the next bit and emits a strobe with `mii_rx_dv_o`=1, `mii_rx_er_o`=0 and `mii_rxd_o`=0101.
- R4: The K group and each following data group give one nibble with data valid high. K gives 0101. The data groups map as 0=11110, 1=01001, 2=10100, 3=10101, 4=01010, 5=01011, 6=01110, 7=01111, 8=10010, 9=10011, A=10110, B=10111, C=11010, D=11011, E=11100, F=11101. A group's nibble is presented when the following group completes.
- R5: `nib_stb_o` is high for one cycle per output update. Between strobes the data, valid and error outputs hold.
- R6: T=01101 followed by R=00111 ends the frame. The strobe carries `mii_rx_dv_o`=0, `mii_rx_er_o`=0, `mii_rxd_o`=0000 and `mii_crs_o`=0, and neither symbol produces a nibble.
- R7: Two consecutive idle groups I=11111 inside a frame end it in the same way as R6.
- R8: Inside a frame, a group is flagged with `mii_rx_dv_o`=1 and `mii_rx_er_o`=1, with arbitrary data, in three cases: it is neither data nor T nor I; it is a T not followed by R; or it is an I not followed by I.
- R9: A failed delimiter compare gives a strobe with `mii_rxd_o`=1110, `mii_rx_er_o`=1, `mii_rx_dv_o`=0 and carrier still high. Groups counted from the next bit then repeat that strobe until a second consecutive idle group, which ends as in R6.
- R10: In reset all outputs are low.
- R11: After a frame ends the search restarts with the earlier bits disregarded, so a new J/K may follow with no gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_bit_vld_i | input | 1 | Bit strobe |
| rx_bit_i | input | 1 | Descrambled serial bit |
| mii_rxd_o | output | 4 | Received nibble |
| mii_rx_dv_o | output | 1 | Receive data valid |
| mii_rx_er_o | output | 1 | Receive error |
| mii_crs_o | output | 1 | Carrier sense |
| nib_stb_o | output | 1 | One-cycle strobe per output update |

## Verification
A wrong group boundary shows up at the ports within one code group. The next nibble after the preamble pair would decode to a wrong value or an error, and a T/R end would be missed, leaving carrier high. A stale search window or a misplaced carrier trigger moves the rise of carrier sense by one or more bits, or raises it falsely between back-to-back frames. For this reason the bench checks carrier on the exact bit of the delimiter and compares every strobe record of each frame, including the closing one.

// File: rtl/pcs_rx_5b4b_pkg.sv
package pcs_rx_5b4b_pkg;
  localparam int CODE_W = 5;
  localparam int NIB_W  = 4;
  localparam int WIN_W  = 2 * CODE_W;

  localparam logic [CODE_W-1:0] CG_J = 5'b11000;
  localparam logic [CODE_W-1:0] CG_K = 5'b10001;
  localparam logic [CODE_W-1:0] CG_T = 5'b01101;
  localparam logic [CODE_W-1:0] CG_R = 5'b00111;
  localparam logic [CODE_W-1:0] CG_I = 5'b11111;

  localparam logic [NIB_W-1:0] NIB_PRE    = 4'b0101;
  localparam logic [NIB_W-1:0] NIB_BADSSD = 4'b1110;

  typedef enum logic [2:0] {
    GC_DATA,
    GC_T,
    GC_R,
    GC_IDLE,
    GC_BAD
  } grp_cls_e;

  typedef struct packed {
    grp_cls_e          cls;
    logic [NIB_W-1:0]  nib;
  } grp_t;

  typedef enum logic [1:0] {
    ST_SEARCH,
    ST_CHECK,
    ST_FRAME,
    ST_BAD
  } rx_st_e;
endpackage

// File: rtl/pcs_rx_grp_dec.sv
module pcs_rx_grp_dec
  import pcs_rx_5b4b_pkg::*;
(
  input  logic [CODE_W-1:0] code_i,
  output grp_t              grp_o
);
  always_comb begin
    grp_o.cls = GC_DATA;
    grp_o.nib = code_i[NIB_W-1:0];
    unique case (code_i)
      5'b11110: grp_o.nib = 4'h0;
      5'b01001: grp_o.nib = 4'h1;
      5'b10100: grp_o.nib = 4'h2;
      5'b10101: grp_o.nib = 4'h3;
      5'b01010: grp_o.nib = 4'h4;
      5'b01011: grp_o.nib = 4'h5;
      5'b01110: grp_o.nib = 4'h6;
      5'b01111: grp_o.nib = 4'h7;
      5'b10010: grp_o.nib = 4'h8;
      5'b10011: grp_o.nib = 4'h9;
      5'b10110: grp_o.nib = 4'hA;
      5'b10111: grp_o.nib = 4'hB;
      5'b11010: grp_o.nib = 4'hC;
      5'b11011: grp_o.nib = 4'hD;
      5'b11100: grp_o.nib = 4'hE;
      5'b11101: grp_o.nib = 4'hF;
      CG_T:     grp_o.cls = GC_T;
      CG_R:     grp_o.cls = GC_R;
      CG_I:     grp_o.cls = GC_IDLE;
      default:  grp_o.cls = GC_BAD;
    endcase
  end
endmodule

// File: rtl/pcs_rx_shifter.sv
module pcs_rx_shifter #(
  parameter int WIN_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bit_vld_i,
  input  logic             bit_i,
  input  logic             flush_i,
  output logic [WIN_W-1:0] win_o
);
  logic [WIN_W-2:0] hist_q;

  assign win_o = {hist_q, bit_i};

  // history reloads with ones so a new search ignores the old frame
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hist_q <= '1;
    end else if (bit_vld_i) begin
      hist_q <= flush_i ? '1 : win_o[WIN_W-2:0];
    end
  end
endmodule

// File: rtl/pcs_rx_carrier_det.sv
module pcs_rx_carrier_det
  import pcs_rx_5b4b_pkg::*;
(
  input  logic [WIN_W-1:0] win_i,
  output logic             cs_hit_o,
  output logic             ssd_hit_o
);
  // new zero, one before it, another zero further back: non-adjacent pair
  assign cs_hit_o  = !win_i[0] && win_i[1] && !(&win_i[WIN_W-1:2]);
  assign ssd_hit_o = (win_i == {CG_J, CG_K});
endmodule

// File: rtl/pcs_rx_ctrl.sv
module pcs_rx_ctrl
  import pcs_rx_5b4b_pkg::*;
#(
  parameter int SSD_LAG = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bit_vld_i,
  input  logic             cs_hit_i,
  input  logic             ssd_hit_i,
  input  grp_t             grp_i,
  output logic             flush_o,
  output logic [NIB_W-1:0] rxd_o,
  output logic             rx_dv_o,
  output logic             rx_er_o,
  output logic             crs_o,
  output logic             stb_o
);
  localparam int CNT_MAX = (CODE_W > SSD_LAG) ? CODE_W : SSD_LAG;
  localparam int CNT_W   = $clog2(CNT_MAX);

  rx_st_e           st_q;
  logic [CNT_W-1:0] cnt_q;
  grp_t             pend_q;
  logic             prev_idle_q;

  logic grp_done, chk_done, frame_end, bad_end, go_end;

  assign grp_done  = (cnt_q == CNT_W'(CODE_W - 1));
  assign chk_done  = (cnt_q == CNT_W'(SSD_LAG - 1));
  assign frame_end = ((pend_q.cls == GC_T) && (grp_i.cls == GC_R)) ||
                     ((pend_q.cls == GC_IDLE) && (grp_i.cls == GC_IDLE));
  assign bad_end   = prev_idle_q && (grp_i.cls == GC_IDLE);
  assign go_end    = bit_vld_i && grp_done &&
                     (((st_q == ST_FRAME) && frame_end) ||
                      ((st_q == ST_BAD) && bad_end));
  assign flush_o   = go_end;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_SEARCH;
      cnt_q       <= '0;
      pend_q      <= '{cls: GC_DATA, nib: '0};
      prev_idle_q <= 1'b0;
      rxd_o       <= '0;
      rx_dv_o     <= 1'b0;
      rx_er_o     <= 1'b0;
      crs_o       <= 1'b0;
      stb_o       <= 1'b0;
    end else begin
      stb_o <= 1'b0;
      if (go_end) begin
        st_q    <= ST_SEARCH;
        cnt_q   <= '0;
        stb_o   <= 1'b1;
        rxd_o   <= '0;
        rx_dv_o <= 1'b0;
        rx_er_o <= 1'b0;
        crs_o   <= 1'b0;
      end else if (bit_vld_i) begin
        unique case (st_q)
          ST_SEARCH: begin
            if (cs_hit_i) begin
              crs_o <= 1'b1;
              cnt_q <= '0;
              st_q  <= ST_CHECK;
            end
          end
          ST_CHECK: begin
            if (chk_done) begin
              cnt_q <= '0;
              stb_o <= 1'b1;
              if (ssd_hit_i) begin
                st_q    <= ST_FRAME;
                rxd_o   <= NIB_PRE;
                rx_dv_o <= 1'b1;
                rx_er_o <= 1'b0;
                pend_q  <= '{cls: GC_DATA, nib: NIB_PRE};
              end else begin
                st_q        <= ST_BAD;
                rxd_o       <= NIB_BADSSD;
                rx_dv_o     <= 1'b0;
                rx_er_o     <= 1'b1;
                prev_idle_q <= 1'b0;
              end
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          ST_FRAME: begin
            if (grp_done) begin
              // output lags one group so T/R and I/I pairs never leak data
              cnt_q   <= '0;
              stb_o   <= 1'b1;
              rxd_o   <= pend_q.nib;
              rx_dv_o <= 1'b1;
              rx_er_o <= (pend_q.cls != GC_DATA);
              pend_q  <= grp_i;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          ST_BAD: begin
            if (grp_done) begin
              cnt_q       <= '0;
              stb_o       <= 1'b1;
              rxd_o       <= NIB_BADSSD;
              rx_dv_o     <= 1'b0;
              rx_er_o     <= 1'b1;
              prev_idle_q <= (grp_i.cls == GC_IDLE);
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          default: st_q <= ST_SEARCH;
        endcase
      end
    end
  end
endmodule

// File: rtl/pcs_rx_5b4b.sv
module pcs_rx_5b4b
  import pcs_rx_5b4b_pkg::*;
#(
  parameter int SSD_LAG = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rx_bit_vld_i,
  input  logic             rx_bit_i,
  output logic [NIB_W-1:0] mii_rxd_o,
  output logic             mii_rx_dv_o,
  output logic             mii_rx_er_o,
  output logic             mii_crs_o,
  output logic             nib_stb_o
);
  logic [WIN_W-1:0] win;
  logic             flush, cs_hit, ssd_hit;
  grp_t             grp;

  pcs_rx_shifter #(.WIN_W(WIN_W)) u_shift (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .bit_vld_i (rx_bit_vld_i),
    .bit_i     (rx_bit_i),
    .flush_i   (flush),
    .win_o     (win)
  );

  pcs_rx_carrier_det u_cdet (
    .win_i     (win),
    .cs_hit_o  (cs_hit),
    .ssd_hit_o (ssd_hit)
  );

  pcs_rx_grp_dec u_dec (
    .code_i (win[CODE_W-1:0]),
    .grp_o  (grp)
  );

  pcs_rx_ctrl #(.SSD_LAG(SSD_LAG)) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .bit_vld_i (rx_bit_vld_i),
    .cs_hit_i  (cs_hit),
    .ssd_hit_i (ssd_hit),
    .grp_i     (grp),
    .flush_o   (flush),
    .rxd_o     (mii_rxd_o),
    .rx_dv_o   (mii_rx_dv_o),
    .rx_er_o   (mii_rx_er_o),
    .crs_o     (mii_crs_o),
    .stb_o     (nib_stb_o)
  );
endmodule

// File: rtl/pcs_rx_5b4b_chk.sv
module pcs_rx_5b4b_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       rx_bit_vld_i,
  input logic [3:0] mii_rxd_o,
  input logic       mii_rx_dv_o,
  input logic       mii_rx_er_o,
  input logic       mii_crs_o,
  input logic       nib_stb_o
);
  p_stb_needs_bit_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nib_stb_o |-> $past(rx_bit_vld_i));

  p_dv_rise_preamble_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mii_rx_dv_o) |-> (mii_rxd_o == 4'b0101) && !mii_rx_er_o && nib_stb_o);

  p_dv_within_crs_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mii_rx_dv_o |-> mii_crs_o);

  p_stb_single_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nib_stb_o |=> !nib_stb_o);

  p_hold_between_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !nib_stb_o |-> $stable({mii_rxd_o, mii_rx_dv_o, mii_rx_er_o}));

  p_crs_fall_clean_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mii_crs_o) |-> nib_stb_o && !mii_rx_dv_o && !mii_rx_er_o);

  p_bad_ssd_value_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mii_rx_er_o && !mii_rx_dv_o) |-> (mii_rxd_o == 4'b1110) && mii_crs_o);
endmodule

bind pcs_rx_5b4b pcs_rx_5b4b_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .rx_bit_vld_i (rx_bit_vld_i),
  .mii_rxd_o    (mii_rxd_o),
  .mii_rx_dv_o  (mii_rx_dv_o),
  .mii_rx_er_o  (mii_rx_er_o),
  .mii_crs_o    (mii_crs_o),
  .nib_stb_o    (nib_stb_o)
);

// File: tb/pcs_rx_5b4b_tb_top.sv
module pcs_rx_5b4b_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       vld = 1'b0;
  logic       bitv = 1'b0;
  logic [3:0] rxd;
  logic       dv, er, crs, stb;

  always #5 clk = ~clk;

  pcs_rx_5b4b dut_i (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .rx_bit_vld_i (vld),
    .rx_bit_i     (bitv),
    .mii_rxd_o    (rxd),
    .mii_rx_dv_o  (dv),
    .mii_rx_er_o  (er),
    .mii_crs_o    (crs),
    .nib_stb_o    (stb)
  );

  typedef struct {
    logic [3:0] rxd;
    logic       dv;
    logic       er;
    logic       crs;
    bit         rxd_x;
    string      req;
  } rec_t;

  rec_t got_q[$];
  rec_t exp_q[$];
  int   n_chk = 0;
  int   n_fail = 0;
  int   gap_pct = 25;

  localparam logic [4:0] J = 5'b11000, K = 5'b10001, T = 5'b01101,
                         R = 5'b00111, I = 5'b11111;

  always @(posedge clk) begin
    #1;
    if (rst_n && stb) got_q.push_back('{rxd, dv, er, crs, 1'b0, ""});
  end

  function automatic logic [4:0] enc(int d);
    case (d)
      0: return 5'b11110;  1: return 5'b01001;  2: return 5'b10100;  3: return 5'b10101;
      4: return 5'b01010;  5: return 5'b01011;  6: return 5'b01110;  7: return 5'b01111;
      8: return 5'b10010;  9: return 5'b10011; 10: return 5'b10110; 11: return 5'b10111;
     12: return 5'b11010; 13: return 5'b11011; 14: return 5'b11100; default: return 5'b11101;
    endcase
  endfunction

  function automatic bit is_data(logic [4:0] c);
    for (int d = 0; d < 16; d++) if (enc(d) == c) return 1'b1;
    return 1'b0;
  endfunction

  task automatic check(bit ok, string req, string what, string act, string exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%s expected=%s", req, what, act, exp);
    end
  endtask

  task automatic exp_nib(logic [3:0] n, string req);
    exp_q.push_back('{n, 1'b1, 1'b0, 1'b1, 1'b0, req});
  endtask
  task automatic exp_err(string req);
    exp_q.push_back('{4'h0, 1'b1, 1'b1, 1'b1, 1'b1, req});
  endtask
  task automatic exp_bad(string req);
    exp_q.push_back('{4'hE, 1'b0, 1'b1, 1'b1, 1'b0, req});
  endtask
  task automatic exp_end(string req);
    exp_q.push_back('{4'h0, 1'b0, 1'b0, 1'b0, 1'b0, req});
  endtask

  // R1: idle cycles carry random bit values that must be ignored
  task automatic send_bit(bit b);
    if ($urandom_range(0, 99) < gap_pct) begin
      @(negedge clk);
      vld  = 1'b0;
      bitv = 1'($urandom);
    end
    @(negedge clk);
    vld  = 1'b1;
    bitv = b;
    @(posedge clk);
    #1;
    vld  = 1'b0;
  endtask

  task automatic send_grp(logic [4:0] g);
    for (int i = 4; i >= 0; i--) send_bit(g[i]);
  endtask

  task automatic send_ones(int n);
    for (int i = 0; i < n; i++) send_bit(1'b1);
  endtask

  task automatic start_frame();
    logic [9:0] jk;
    jk = {J, K};
    for (int i = 9; i >= 0; i--) begin
      send_bit(jk[i]);
      if (i == 4) check(crs == 1'b0, "R2", "crs before break", $sformatf("%0b", crs), "0");
      if (i == 3) check(crs == 1'b1, "R2", "crs at break", $sformatf("%0b", crs), "1");
    end
    exp_nib(4'h5, "R3");
    exp_nib(4'h5, "R4");
  endtask

  task automatic compare(string tag);
    repeat (3) @(negedge clk);
    check(got_q.size() == exp_q.size(), tag, "strobe count",
          $sformatf("%0d", got_q.size()), $sformatf("%0d", exp_q.size()));
    for (int i = 0; i < exp_q.size(); i++) begin
      if (i < got_q.size()) begin
        check(got_q[i].dv == exp_q[i].dv && got_q[i].er == exp_q[i].er &&
              got_q[i].crs == exp_q[i].crs &&
              (exp_q[i].rxd_x || got_q[i].rxd == exp_q[i].rxd),
              exp_q[i].req, $sformatf("record %0d (%s)", i, tag),
              $sformatf("rxd=%h dv=%0b er=%0b crs=%0b", got_q[i].rxd, got_q[i].dv, got_q[i].er, got_q[i].crs),
              $sformatf("rxd=%h dv=%0b er=%0b crs=%0b", exp_q[i].rxd, exp_q[i].dv, exp_q[i].er, exp_q[i].crs));
      end
    end
    check(stb == 1'b0, "R5", "strobe idle after frame", $sformatf("%0b", stb), "0");
    got_q.delete();
    exp_q.delete();
  endtask

  task automatic rand_frame();
    int n;
    logic [4:0] x;
    send_ones($urandom_range(0, 15));
    start_frame();
    n = $urandom_range(0, 10);
    for (int k = 0; k < n; k++) begin
      int r;
      int d;
      r = $urandom_range(0, 9);
      d = $urandom_range(0, 15);
      if (r == 0) begin
        do x = 5'($urandom); while (is_data(x) || x == T || x == I);
        send_grp(x);
        exp_err("R8");
      end else if (r == 1) begin
        send_grp($urandom_range(0, 1) ? T : I);
        exp_err("R8");
        send_grp(enc(d));
        exp_nib(4'(d), "R4");
      end else begin
        send_grp(enc(d));
        exp_nib(4'(d), "R4");
      end
    end
    if ($urandom_range(0, 1)) begin
      send_grp(T); send_grp(R); exp_end("R6");
    end else begin
      send_grp(I); send_grp(I); exp_end("R7");
    end
    compare("random");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog all requirements actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int sz;
    void'($urandom(32'd7719));
    repeat (3) @(negedge clk);
    check({rxd, dv, er, crs, stb} == 8'h00, "R10", "reset outputs",
          $sformatf("%h", {rxd, dv, er, crs, stb}), "00");
    rst_n = 1'b1;

    // R2: a long run of ones gives no carrier and no strobe
    send_ones(40);
    check(crs == 1'b0, "R2", "crs on idle", $sformatf("%0b", crs), "0");
    compare("idle");

    // R4/R6: every data code, T/R end
    start_frame();
    for (int d = 0; d < 16; d++) begin
      send_grp(enc(d));
      exp_nib(4'(d), "R4");
    end
    send_grp(T); send_grp(R); exp_end("R6");
    compare("all codes");

    // R6: empty frame, then R11 a frame right behind it
    start_frame();
    send_grp(T); send_grp(R); exp_end("R6");
    start_frame();
    send_grp(enc(9)); exp_nib(4'h9, "R11");
    send_grp(T); send_grp(R); exp_end("R11");
    compare("back to back");

    // R7: idle pair ends; R1: long invalid stretch mid frame
    start_frame();
    send_grp(enc(3)); exp_nib(4'h3, "R4");
    sz = got_q.size();
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      vld  = 1'b0;
      bitv = 1'($urandom);
    end
    @(negedge clk);
    check(got_q.size() == sz && crs == 1'b1, "R1", "no change while invalid",
          $sformatf("n=%0d crs=%0b", got_q.size(), crs), $sformatf("n=%0d crs=1", sz));
    send_grp(enc(12)); exp_nib(4'hC, "R1");
    send_grp(I); send_grp(I); exp_end("R7");
    compare("idle end");

    // R8: lone T and lone I inside a frame
    start_frame();
    send_grp(enc(1)); exp_nib(4'h1, "R4");
    send_grp(T);      exp_err("R8");
    send_grp(enc(2)); exp_nib(4'h2, "R4");
    send_grp(I);      exp_err("R8");
    send_grp(enc(7)); exp_nib(4'h7, "R4");
    send_grp(R);      exp_err("R8");
    send_grp(T); send_grp(R); exp_end("R6");
    compare("lone symbols");

    // R9: J then a data group, carrier rises but delimiter fails
    send_grp(J);
    send_grp(enc(1));
    send_ones(12);
    exp_bad("R9");
    exp_bad("R9");
    exp_end("R9");
    compare("bad delimiter");

    for (int f = 0; f < 40; f++) rand_frame();

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule